// File: doc/BRIEF.md
# Threshold-Driven FIFO Interrupt Controller

This block is the interrupt and status register group that sits beside a serial master's transmit and receive FIFOs. It never touches FIFO data. Instead, it watches the two occupancy counts and compares each one against a threshold that software writes. From those comparisons and from four event pulses raised elsewhere in the master, it keeps a seven-bit status word. Software clears that word one bit at a time by writing ones.

Software never writes the interrupt mask directly. One register address turns mask bits on and a second address turns them off, so two code paths can change different bits without a read-modify-write. The mask itself can be read back at a third address. A single interrupt line is raised whenever any status bit is set and enabled.

The register bus is a simple single-cycle strobe. A write takes effect at the clock edge where `regWrEn` is high. Read data is combinational from `regAddr`.

Top module: `fifo_irq_top`

## Requirements
- R1: While reset is held and with both levels at 0, the status reads 0 at offset 0x04 and the mask reads 0 at offset 0x10. The transmit threshold at 0x28 reads 1, the receive threshold at 0x2C reads `RX_THR_RST` (default 32), and `irq` is low.
- R2: Writing a value to offset 0x08 sets every mask bit whose data bit (6:0) is 1. Mask bits written as 0 keep their value.
- R3: Writing a value to offset 0x0C clears every mask bit whose data bit is 1. Mask bits written as 0 keep their value.
- R4: Status bit 2 latches at a clock edge where the transmit level is below the transmit threshold. It stays set after the level rises again until it is cleared. A threshold of 0 never sets it, and a threshold of 1 sets it exactly when the transmit FIFO is empty.
- R5: Status bit 4 always equals "receive level is not zero" in the same cycle. Writing 1 to it at 0x04 leaves no lasting effect.
- R6: Status bit 6 latches at a clock edge where the receive threshold is not zero and the receive level is at or above it. It stays set until cleared. A receive threshold of 0 disables this event.
- R7: The pulse inputs `extEvent[0]`, `[1]`, `[2]` and `[3]` latch status bits 0, 1, 3 and 5 respectively.
- R8: A write to 0x04 clears exactly the latched bits written as 1. If a bit's set condition holds at that same edge, the set wins and the bit stays 1.
- R9: `irq` is high exactly when at least one status bit is both set and enabled in the mask.
- R10: The thresholds at 0x28 and 0x2C store the low `LEVEL_W` bits (6 by default) of the written data and read back with the upper bits as 0.
- R11: Reads of 0x08, 0x0C and any unmapped offset return 0. Writes to unmapped offsets change neither the mask, the thresholds nor the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register byte offset |
| regWrData | input | DATA_W | Write data |
| regRdData | output | DATA_W | Combinational read data for `regAddr` |
| txLevel | input | LEVEL_W | Transmit FIFO occupancy |
| rxLevel | input | LEVEL_W | Receive FIFO occupancy |
| extEvent | input | 4 | One-cycle event pulses for status bits 0, 1, 3, 5 |
| irq | output | 1 | Interrupt request |

## Verification
If a sticky status flop or a mask bit holds a wrong value, the error shows at the ports the cycle after the edge that caused it. It appears both as a wrong read at 0x04 or 0x10 and as a wrong `irq` level whenever the mask enables that bit. An error in the level comparators shows up one edge after the levels are applied. The bench therefore sweeps every threshold from 0 to 4 against every level from 0 to 5, where off-by-one and "greater-or-equal versus greater" faults live. It walks all 128 mask values against fixed status patterns, and all 16 clear patterns over the latched bits. A live bit that had wrongly been made sticky would show as a 1 on the read right after the receive level drops to 0.

// File: rtl/fifo_irq_pkg.sv
package fifo_irq_pkg;

  localparam int unsigned NUM_EVT = 7;
  localparam int unsigned NUM_EXT = 4;

  // status bit positions that software decodes
  localparam int unsigned BIT_TX_LOW  = 2;
  localparam int unsigned BIT_RX_NE   = 4;
  localparam int unsigned BIT_RX_THR  = 6;

  // register byte offsets
  localparam int unsigned OFF_STATUS   = 'h04;
  localparam int unsigned OFF_MASK_SET = 'h08;
  localparam int unsigned OFF_MASK_CLR = 'h0C;
  localparam int unsigned OFF_MASK_RD  = 'h10;
  localparam int unsigned OFF_TX_THR   = 'h28;
  localparam int unsigned OFF_RX_THR   = 'h2C;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_STATUS,
    RD_MASK,
    RD_TX_THR,
    RD_RX_THR
  } rdSel_t;

  typedef struct packed {
    logic   wrStatus;
    logic   wrMaskSet;
    logic   wrMaskClr;
    logic   wrTxThr;
    logic   wrRxThr;
    rdSel_t rdSel;
  } regStrobe_t;

  // status bit driven by external event input k
  function automatic int unsigned extBit(input int unsigned k);
    case (k)
      0:       extBit = 0;
      1:       extBit = 1;
      2:       extBit = 3;
      default: extBit = 5;
    endcase
  endfunction

endpackage

// File: rtl/fifo_irq_ctrl.sv
module fifo_irq_ctrl
  import fifo_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output regStrobe_t        strobe
);

  localparam logic [ADDR_W-1:0] A_STATUS   = ADDR_W'(OFF_STATUS);
  localparam logic [ADDR_W-1:0] A_MASK_SET = ADDR_W'(OFF_MASK_SET);
  localparam logic [ADDR_W-1:0] A_MASK_CLR = ADDR_W'(OFF_MASK_CLR);
  localparam logic [ADDR_W-1:0] A_MASK_RD  = ADDR_W'(OFF_MASK_RD);
  localparam logic [ADDR_W-1:0] A_TX_THR   = ADDR_W'(OFF_TX_THR);
  localparam logic [ADDR_W-1:0] A_RX_THR   = ADDR_W'(OFF_RX_THR);

  logic hitStatus, hitSet, hitClr, hitMaskRd, hitTx, hitRx;

  always_comb begin
    hitStatus = (regAddr == A_STATUS);
    hitSet    = (regAddr == A_MASK_SET);
    hitClr    = (regAddr == A_MASK_CLR);
    hitMaskRd = (regAddr == A_MASK_RD);
    hitTx     = (regAddr == A_TX_THR);
    hitRx     = (regAddr == A_RX_THR);
  end

  always_comb begin
    strobe.wrStatus  = regWrEn && hitStatus;
    strobe.wrMaskSet = regWrEn && hitSet;
    strobe.wrMaskClr = regWrEn && hitClr;
    strobe.wrTxThr   = regWrEn && hitTx;
    strobe.wrRxThr   = regWrEn && hitRx;
    if (hitStatus)      strobe.rdSel = RD_STATUS;
    else if (hitMaskRd) strobe.rdSel = RD_MASK;
    else if (hitTx)     strobe.rdSel = RD_TX_THR;
    else if (hitRx)     strobe.rdSel = RD_RX_THR;
    else                strobe.rdSel = RD_NONE;
  end

endmodule

// File: rtl/fifo_irq_dp.sv
module fifo_irq_dp
  import fifo_irq_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned LEVEL_W    = 6,
  parameter int unsigned TX_THR_RST = 1,
  parameter int unsigned RX_THR_RST = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  regStrobe_t         strobe,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [LEVEL_W-1:0] txLevel,
  input  logic [LEVEL_W-1:0] rxLevel,
  input  logic [NUM_EXT-1:0] extEvent,
  output logic [DATA_W-1:0]  rdData,
  output logic               irq,
  output logic [NUM_EVT-1:0] maskQ,
  output logic [NUM_EVT-1:0] statusView,
  output logic [LEVEL_W-1:0] txThrQ,
  output logic [LEVEL_W-1:0] rxThrQ
);

  logic [NUM_EVT-1:0] evtSet;
  logic [NUM_EVT-1:0] setBits;
  logic [NUM_EVT-1:0] clrBits;
  logic               txLow;
  logic               rxHit;
  logic               unusedWrHigh;

  assign unusedWrHigh = ^wrData[DATA_W-1:NUM_EVT];

  // level comparators
  always_comb begin
    txLow = (txLevel < txThrQ);
    rxHit = (rxThrQ != '0) && (rxLevel >= rxThrQ);
  end

  // event sources per status bit
  always_comb begin
    evtSet             = '0;
    evtSet[BIT_TX_LOW] = txLow;
    evtSet[BIT_RX_NE]  = (rxLevel != '0);
    evtSet[BIT_RX_THR] = rxHit;
    for (int k = 0; k < NUM_EXT; k++) begin
      evtSet[extBit(k)] = extEvent[k];
    end
  end

  // status: one live bit, the rest sticky with write-one-to-clear
  for (genvar b = 0; b < NUM_EVT; b++) begin : g_evt
    if (b == BIT_RX_NE) begin : g_live
      assign statusView[b] = evtSet[b];
    end else begin : g_sticky
      logic bitQ;
      logic clrHit;
      assign clrHit = strobe.wrStatus && wrData[b];
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)          bitQ <= 1'b0;
        else if (evtSet[b]) bitQ <= 1'b1;
        else if (clrHit)    bitQ <= 1'b0;
      end
      assign statusView[b] = bitQ;
    end
  end

  // mask: set-only and clear-only write ports
  always_comb begin
    setBits = strobe.wrMaskSet ? wrData[NUM_EVT-1:0] : '0;
    clrBits = strobe.wrMaskClr ? wrData[NUM_EVT-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) maskQ <= '0;
    else       maskQ <= (maskQ | setBits) & ~clrBits;
  end

  // thresholds
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txThrQ <= LEVEL_W'(TX_THR_RST);
      rxThrQ <= LEVEL_W'(RX_THR_RST);
    end else begin
      if (strobe.wrTxThr) txThrQ <= wrData[LEVEL_W-1:0];
      if (strobe.wrRxThr) rxThrQ <= wrData[LEVEL_W-1:0];
    end
  end

  assign irq = |(statusView & maskQ);

  // read mux
  always_comb begin
    rdData = '0;
    case (strobe.rdSel)
      RD_STATUS: rdData[NUM_EVT-1:0] = statusView;
      RD_MASK:   rdData[NUM_EVT-1:0] = maskQ;
      RD_TX_THR: rdData[LEVEL_W-1:0] = txThrQ;
      RD_RX_THR: rdData[LEVEL_W-1:0] = rxThrQ;
      default:   rdData = '0;
    endcase
  end

endmodule

// File: rtl/fifo_irq_top.sv
module fifo_irq_top
  import fifo_irq_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned FIFO_DEPTH = 63,
  parameter int unsigned TX_THR_RST = 1,
  parameter int unsigned RX_THR_RST = 32,
  localparam int unsigned LEVEL_W   = $clog2(FIFO_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  input  logic [LEVEL_W-1:0] txLevel,
  input  logic [LEVEL_W-1:0] rxLevel,
  input  logic [NUM_EXT-1:0] extEvent,
  output logic               irq
);

  regStrobe_t         strobe;
  logic [NUM_EVT-1:0] maskQ;
  logic [NUM_EVT-1:0] statusView;
  logic [LEVEL_W-1:0] txThrQ;
  logic [LEVEL_W-1:0] rxThrQ;

  fifo_irq_ctrl #(
    .ADDR_W(ADDR_W)
  ) u_ctrl (
    .regWrEn(regWrEn),
    .regAddr(regAddr),
    .strobe (strobe)
  );

  fifo_irq_dp #(
    .DATA_W    (DATA_W),
    .LEVEL_W   (LEVEL_W),
    .TX_THR_RST(TX_THR_RST),
    .RX_THR_RST(RX_THR_RST)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrData    (regWrData),
    .txLevel   (txLevel),
    .rxLevel   (rxLevel),
    .extEvent  (extEvent),
    .rdData    (regRdData),
    .irq       (irq),
    .maskQ     (maskQ),
    .statusView(statusView),
    .txThrQ    (txThrQ),
    .rxThrQ    (rxThrQ)
  );

endmodule

// File: rtl/fifo_irq_chk.sv
module fifo_irq_chk
  import fifo_irq_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned LEVEL_W = 6
) (
  input logic               clk,
  input logic               rstN,
  input logic               regWrEn,
  input logic [ADDR_W-1:0]  regAddr,
  input logic [DATA_W-1:0]  regWrData,
  input logic [LEVEL_W-1:0] txLevel,
  input logic [LEVEL_W-1:0] rxLevel,
  input logic               irq,
  input logic [NUM_EVT-1:0] maskQ,
  input logic [NUM_EVT-1:0] statusView,
  input logic [LEVEL_W-1:0] txThrQ,
  input logic [LEVEL_W-1:0] rxThrQ
);

  logic setWr, clrWr;
  assign setWr = regWrEn && (regAddr == ADDR_W'(OFF_MASK_SET));
  assign clrWr = regWrEn && (regAddr == ADDR_W'(OFF_MASK_CLR));

  AST_MASK_SETS: assert property (@(posedge clk) disable iff (!rstN)
    setWr |=> ((maskQ & $past(regWrData[NUM_EVT-1:0])) == $past(regWrData[NUM_EVT-1:0]))); // R2
  AST_MASK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    clrWr |=> ((maskQ & $past(regWrData[NUM_EVT-1:0])) == '0)); // R3
  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !(setWr || clrWr) |=> $stable(maskQ)); // R3
  AST_TX_LOW_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    (txLevel < txThrQ) |=> statusView[BIT_TX_LOW]); // R4
  AST_RX_NE_LIVE: assert property (@(posedge clk) disable iff (!rstN)
    statusView[BIT_RX_NE] == (rxLevel != '0)); // R5
  AST_RX_THR_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    ((rxThrQ != '0) && (rxLevel >= rxThrQ)) |=> statusView[BIT_RX_THR]); // R6
  AST_IRQ_MASKED_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ == '0) |-> !irq); // R9

endmodule

bind fifo_irq_top fifo_irq_chk #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W),
  .LEVEL_W(LEVEL_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regWrEn   (regWrEn),
  .regAddr   (regAddr),
  .regWrData (regWrData),
  .txLevel   (txLevel),
  .rxLevel   (rxLevel),
  .irq       (irq),
  .maskQ     (maskQ),
  .statusView(statusView),
  .txThrQ    (txThrQ),
  .rxThrQ    (rxThrQ)
);

// File: tb/test_fifo_irq_top.sv
`timescale 1ns/1ps
module test_fifo_irq_top;

  localparam int LW = 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [LW-1:0] txLevel = '0;
  logic [LW-1:0] rxLevel = '0;
  logic [3:0]  extEvent = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fifo_irq_top i_fifo_irq_top (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .txLevel(txLevel),
    .rxLevel(rxLevel), .extEvent(extEvent), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic pulse(input logic [3:0] v);
    @(negedge clk);
    extEvent = v;
    @(negedge clk);
    extEvent = '0;
  endtask

  function automatic logic [6:0] mapExt(input logic [3:0] v);
    return {1'b0, v[3], 1'b0, v[2], 1'b0, v[1], v[0]};
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    // R1 reset state
    repeat (3) tick();
    rd(8'h04, d); chk("R1 status", d, 32'h0);
    rd(8'h10, d); chk("R1 mask", d, 32'h0);
    rd(8'h28, d); chk("R1 txThr", d, 32'd1);
    rd(8'h2C, d); chk("R1 rxThr", d, 32'd32);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    tick(); rstN = 1'b1;
    tick();
    // R4 threshold 1 with empty transmit FIFO
    rd(8'h04, d); chk("R4 empty flag", d, 32'h04);
    txLevel = 6'd63;
    wr(8'h04, 32'h7F);
    rd(8'h04, d); chk("R4 cleared", d, 32'h0);

    // R4 sweep threshold x level
    for (int t = 0; t <= 4; t++) begin
      for (int l = 0; l <= 5; l++) begin
        txLevel = LW'(l);
        wr(8'h28, t);
        wr(8'h04, 32'h04);
        rd(8'h04, d); chk("R4 latch", d, (l < t) ? 32'h04 : 32'h0);
        txLevel = 6'd63;
        tick();
        rd(8'h04, d); chk("R4 sticky", d, (l < t) ? 32'h04 : 32'h0);
        wr(8'h04, 32'h04);
        rd(8'h04, d); chk("R4 clear", d, 32'h0);
      end
    end
    wr(8'h28, 32'd1);

    // R6 / R5 sweep
    for (int t = 0; t <= 4; t++) begin
      for (int l = 0; l <= 5; l++) begin
        logic [31:0] e6;
        e6 = (t != 0 && l >= t) ? 32'h40 : 32'h0;
        rxLevel = LW'(l);
        wr(8'h2C, t);
        wr(8'h04, 32'h50);
        rd(8'h04, d); chk("R6 R5 latch and live", d, e6 | ((l != 0) ? 32'h10 : 32'h0));
        rxLevel = '0;
        tick();
        rd(8'h04, d); chk("R5 drop R6 sticky", d, e6);
        wr(8'h04, 32'h40);
      end
    end
    wr(8'h2C, 32'd0);

    // R7 each external event alone
    for (int k = 0; k < 4; k++) begin
      pulse(4'(1 << k));
      rd(8'h04, d); chk("R7 ext map", d, {25'b0, mapExt(4'(1 << k))});
      wr(8'h04, 32'h7F);
    end

    // R8 all clear patterns
    for (int p = 0; p < 16; p++) begin
      pulse(4'hF);
      wr(8'h04, {25'b0, mapExt(4'(p))});
      rd(8'h04, d); chk("R8 exact clear", d, 32'h2B & ~{25'b0, mapExt(4'(p))});
      wr(8'h04, 32'h7F);
    end
    // R8 set wins over clear
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 8'h04; regWrData = 32'h01; extEvent = 4'h1;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0; extEvent = '0;
    rd(8'h04, d); chk("R8 set wins", d, 32'h01);
    wr(8'h04, 32'h7F);

    // R9 mask sweep with status 0x3B
    pulse(4'hF);
    rxLevel = 6'd1;
    for (int m = 0; m < 128; m++) begin
      wr(8'h0C, 32'h7F);
      wr(8'h08, m);
      rd(8'h10, d); chk("R2 R3 mask readback", d, m);
      chk("R9 irq", {31'b0, irq}, ((m & 'h3B) != 0) ? 32'h1 : 32'h0);
    end
    // R2 / R3 incremental
    wr(8'h0C, 32'h7F);
    wr(8'h08, 32'h55);
    wr(8'h08, 32'h0A);
    rd(8'h10, d); chk("R2 set or", d, 32'h5F);
    wr(8'h08, 32'h0);
    rd(8'h10, d); chk("R2 zero no effect", d, 32'h5F);
    wr(8'h0C, 32'h41);
    rd(8'h10, d); chk("R3 clear", d, 32'h1E);
    wr(8'h0C, 32'h0);
    rd(8'h10, d); chk("R3 zero no effect", d, 32'h1E);
    // R9 no status -> no irq
    rxLevel = '0;
    wr(8'h04, 32'h7F);
    wr(8'h08, 32'h7F);
    rd(8'h04, d); chk("R9 status empty", d, 32'h0);
    chk("R9 irq low", {31'b0, irq}, 32'h0);

    // R10 threshold width
    wr(8'h28, 32'hFFFF_FFC5);
    rd(8'h28, d); chk("R10 txThr", d, 32'h05);
    wr(8'h2C, 32'hABCD_EF3A);
    rd(8'h2C, d); chk("R10 rxThr", d, 32'h3A);
    wr(8'h2C, 32'h0);
    wr(8'h28, 32'h1);

    // R11 unmapped and write-only offsets
    wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h1C, 32'h0);
    rd(8'h10, d); chk("R11 mask kept", d, 32'h7F);
    rd(8'h28, d); chk("R11 txThr kept", d, 32'h01);
    rd(8'h04, d); chk("R11 status kept", d, 32'h0);
    rd(8'h14, d); chk("R11 unmapped read", d, 32'h0);
    rd(8'h08, d); chk("R11 set reg read", d, 32'h0);
    rd(8'h0C, d); chk("R11 clr reg read", d, 32'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule